// File: doc/BRIEF.md
# Floating-Point Set-on-Compare Flag Unit

This block evaluates one ordering relation between two floating-point operands and keeps the answer in a one-bit status flag. Each operand arrives as a pair of 32-bit words taken from an even-numbered register and the odd register after it. A precision select decides how the words are read. In single precision only the even word is used. In double precision the even word is the upper half of a 64-bit value and the odd word is the lower half.

A 3-bit predicate code picks one of six relations. The block orders operands by sign and magnitude, treats the two signed zeros as equal, and treats any comparison that involves a NaN as unordered. The result is written into the flag register on a clock edge when the compare-valid input is high. Downstream branch logic reads the flag.

Top module: `fp_cmp_flag`

## Requirements
- R1: While `rst_n` is low, and after it is released, `flag_q` is 0 until the first qualifying write.
- R2: `flag_q` changes only on a rising clock edge where `cmp_valid` is 1. With `cmp_valid` at 0 it holds its value.
- R3: Predicate codes 3'b000, 3'b001 and 3'b010 write 1 when A<B, A>B and A==B respectively, and write 0 otherwise.
- R4: Predicate codes 3'b011, 3'b100 and 3'b101 write 1 when A<=B, A>=B and A!=B respectively, and write 0 otherwise.
- R5: Predicate codes 3'b110 and 3'b111 leave `flag_q` unchanged even when `cmp_valid` is 1.
- R6: With `dbl_sel`=0, each operand is the single-precision value in its even word (sign bit 31, exponent bits 30:23, fraction bits 22:0). The odd words have no effect.
- R7: With `dbl_sel`=1, each operand is {even word, odd word} read as a double-precision value (sign bit 63, exponent bits 62:52, fraction bits 51:0).
- R8: +0 and -0 compare equal in both precisions.
- R9: If either operand is a NaN (exponent all ones, fraction non-zero), predicate 3'b101 writes 1 and every other valid predicate writes 0.
- R10: Non-NaN operands are ordered by sign first and then by magnitude, reversed for negatives, with infinities at the ends of the range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| cmp_valid | input | 1 | A compare is presented this cycle |
| dbl_sel | input | 1 | 1 selects double precision, 0 selects single |
| pred | input | 3 | Relation code |
| a_even | input | 32 | Even-register word of operand A |
| a_odd | input | 32 | Odd-register word of operand A |
| b_even | input | 32 | Even-register word of operand B |
| b_odd | input | 32 | Odd-register word of operand B |
| flag_q | output | 1 | Registered compare status flag |

## Verification
The hardest cases to reach are operands that differ only in the low odd word of a double, and operands that are both zero with opposite signs. Uniform random words almost never produce either. The stimulus therefore draws many operands from a small pool of special values (signed zeros, infinities, NaNs). It also often derives B from A, either by copying it or by changing its lowest bit. It adds directed vectors in which the odd words disagree while the precision select is single.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int WORD_W   = 32;
  localparam int SP_EXP_W = 8;
  localparam int SP_MAN_W = 23;
  localparam int DP_EXP_W = 11;
  localparam int DP_MAN_W = 52;
  localparam int MAG_W    = DP_EXP_W + DP_MAN_W;

  typedef enum logic [2:0] {
    PR_LT  = 3'b000,
    PR_GT  = 3'b001,
    PR_EQ  = 3'b010,
    PR_LE  = 3'b011,
    PR_GE  = 3'b100,
    PR_NE  = 3'b101,
    PR_RS6 = 3'b110,
    PR_RS7 = 3'b111
  } pred_e;

  typedef struct packed {
    logic             nan;
    logic             zero;
    logic             neg;
    logic [MAG_W-1:0] mag;
  } opnd_t;

  typedef struct packed {
    logic unord;
    logic lt;
    logic eq;
    logic gt;
  } rel_t;
endpackage

// File: rtl/fcmp_unpack.sv
module fcmp_unpack
  import fcmp_pkg::*;
(
  input  logic              dbl,
  input  logic [WORD_W-1:0] even_w,
  input  logic [WORD_W-1:0] odd_w,
  output opnd_t             op
);
  localparam int SP_W = 1 + SP_EXP_W + SP_MAN_W;
  localparam int DP_W = 1 + DP_EXP_W + DP_MAN_W;

  logic [DP_W-1:0]     dp_bits;
  logic [SP_W-1:0]     sp_bits;
  logic                sp_nan, dp_nan, sign, mag_zero;
  logic [MAG_W-1:0]    mag;

  assign dp_bits = {even_w, odd_w};
  assign sp_bits = even_w[SP_W-1:0];

  assign sp_nan = (&sp_bits[SP_W-2 -: SP_EXP_W]) && (|sp_bits[SP_MAN_W-1:0]);
  assign dp_nan = (&dp_bits[DP_W-2 -: DP_EXP_W]) && (|dp_bits[DP_MAN_W-1:0]);

  always_comb begin
    if (dbl) begin
      sign = dp_bits[DP_W-1];
      mag  = dp_bits[MAG_W-1:0];
    end else begin
      sign = sp_bits[SP_W-1];
      mag  = {{(MAG_W-SP_W+1){1'b0}}, sp_bits[SP_W-2:0]};
    end
    mag_zero = (mag == '0);
    op.nan   = dbl ? dp_nan : sp_nan;
    op.zero  = mag_zero;
    op.neg   = sign & ~mag_zero;
    op.mag   = mag;
  end
endmodule

// File: rtl/fcmp_relate.sv
module fcmp_relate
  import fcmp_pkg::*;
(
  input  opnd_t a,
  input  opnd_t b,
  output rel_t  rel
);
  logic mag_a_lt, mag_b_lt, mag_same, unord, lt_v, eq_v;

  assign mag_a_lt = (a.mag < b.mag);
  assign mag_b_lt = (b.mag < a.mag);
  assign mag_same = (a.mag == b.mag);
  assign unord    = a.nan | b.nan;

  always_comb begin
    eq_v = (a.neg == b.neg) && mag_same;
    unique case ({a.neg, b.neg})
      2'b10:   lt_v = 1'b1;
      2'b01:   lt_v = 1'b0;
      2'b00:   lt_v = mag_a_lt;
      default: lt_v = mag_b_lt;
    endcase
    rel.unord = unord;
    rel.eq    = ~unord & eq_v;
    rel.lt    = ~unord & lt_v;
    rel.gt    = ~unord & ~eq_v & ~lt_v;
  end
endmodule

// File: rtl/fcmp_select.sv
module fcmp_select
  import fcmp_pkg::*;
(
  input  logic [2:0] pred,
  input  rel_t       rel,
  output logic       hit,
  output logic       code_ok
);
  always_comb begin
    hit     = 1'b0;
    code_ok = 1'b1;
    case (pred_e'(pred))
      PR_LT:   hit = rel.lt;
      PR_GT:   hit = rel.gt;
      PR_EQ:   hit = rel.eq;
      PR_LE:   hit = rel.lt | rel.eq;
      PR_GE:   hit = rel.gt | rel.eq;
      PR_NE:   hit = ~rel.eq;
      default: code_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/fcmp_flag_reg.sv
module fcmp_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic d,
  output logic q
);
  logic q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nxt;
  end

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q)); // R2
endmodule

// File: rtl/fp_cmp_flag.sv
module fp_cmp_flag
  import fcmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_valid,
  input  logic              dbl_sel,
  input  logic [2:0]        pred,
  input  logic [WORD_W-1:0] a_even,
  input  logic [WORD_W-1:0] a_odd,
  input  logic [WORD_W-1:0] b_even,
  input  logic [WORD_W-1:0] b_odd,
  output logic              flag_q
);
  localparam int N_OPND = 2;

  logic [N_OPND-1:0][WORD_W-1:0] even_v, odd_v;
  opnd_t [N_OPND-1:0]            ops;
  rel_t                          rel;
  logic                          hit, code_ok, wr_en;

  assign even_v = {b_even, a_even};
  assign odd_v  = {b_odd,  a_odd};

  for (genvar g = 0; g < N_OPND; g++) begin : g_unpack
    fcmp_unpack u_unpack (
      .dbl    (dbl_sel),
      .even_w (even_v[g]),
      .odd_w  (odd_v[g]),
      .op     (ops[g])
    );
  end

  fcmp_relate u_relate (
    .a   (ops[0]),
    .b   (ops[1]),
    .rel (rel)
  );

  fcmp_select u_select (
    .pred    (pred),
    .rel     (rel),
    .hit     (hit),
    .code_ok (code_ok)
  );

  assign wr_en = cmp_valid & code_ok;

  fcmp_flag_reg u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (wr_en),
    .d     (hit),
    .q     (flag_q)
  );

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_valid |=> $stable(flag_q)); // R2
  AST_RSVD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pred[2:1] == 2'b11) |=> $stable(flag_q)); // R5
  AST_REL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({rel.unord, rel.lt, rel.eq, rel.gt})); // R10
  AST_ZERO_EQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ops[0].zero && ops[1].zero && !rel.unord) |-> rel.eq); // R8
  AST_NAN_NE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && pred == 3'b101 && (ops[0].nan || ops[1].nan)) |=> flag_q); // R9
  AST_NAN_EQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && pred == 3'b010 && (ops[0].nan || ops[1].nan)) |=> !flag_q); // R9
endmodule

// File: tb/sim_fp_cmp_flag.sv
module sim_fp_cmp_flag;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmp_valid, dbl_sel;
  logic [2:0]  pred;
  logic [31:0] a_even, a_odd, b_even, b_odd;
  logic        flag_q;

  int n_vec = 0;
  int n_bad = 0;
  bit model = 1'b0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  fp_cmp_flag u0 (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .dbl_sel(dbl_sel),
    .pred(pred), .a_even(a_even), .a_odd(a_odd), .b_even(b_even),
    .b_odd(b_odd), .flag_q(flag_q)
  );

  function automatic bit is_nan(bit dbl, bit [31:0] e, bit [31:0] o);
    if (dbl) return (e[30:20] == 11'h7ff) && ({e[19:0], o} != 0);
    return (e[30:23] == 8'hff) && (e[22:0] != 0);
  endfunction

  function automatic bit [63:0] order_key(bit dbl, bit [31:0] e, bit [31:0] o);
    bit [63:0] v = dbl ? {e, o} : {e, 32'h0};
    if (v[62:0] == 0) v = 64'h0;
    return v[63] ? ~v : (v | 64'h8000_0000_0000_0000);
  endfunction

  function automatic bit ref_hit(bit dbl, bit [2:0] p, bit [31:0] ae, bit [31:0] ao,
                                 bit [31:0] be, bit [31:0] bo);
    bit un = is_nan(dbl, ae, ao) || is_nan(dbl, be, bo);
    bit [63:0] ka = order_key(dbl, ae, ao);
    bit [63:0] kb = order_key(dbl, be, bo);
    case (p)
      3'd0: return !un && ka <  kb;
      3'd1: return !un && ka >  kb;
      3'd2: return !un && ka == kb;
      3'd3: return !un && ka <= kb;
      3'd4: return !un && ka >= kb;
      default: return un || ka != kb;
    endcase
  endfunction

  task automatic check(string tag);
    n_vec++;
    if (flag_q !== model) begin
      n_bad++;
      $display("FAIL %s: flag_q=%b expected=%b (pred=%0d dbl=%0b a=%h_%h b=%h_%h)",
               tag, flag_q, model, pred, dbl_sel, a_even, a_odd, b_even, b_odd);
    end
  endtask

  task automatic apply(bit v, bit d, bit [2:0] p, bit [31:0] ae, bit [31:0] ao,
                       bit [31:0] be, bit [31:0] bo, string tag);
    cmp_valid = v; dbl_sel = d; pred = p;
    a_even = ae; a_odd = ao; b_even = be; b_odd = bo;
    if (v && p < 3'd6) model = ref_hit(d, p, ae, ao, be, bo);
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  function automatic bit [63:0] pick(bit d);
    case ($urandom % 9)
      0: return 64'h0;
      1: return d ? 64'h8000_0000_0000_0000 : 64'h8000_0000_0000_0000;
      2: return d ? 64'h7ff0_0000_0000_0000 : {32'h7f80_0000, $urandom};
      3: return d ? 64'hfff0_0000_0000_0000 : {32'hff80_0000, $urandom};
      4: return d ? 64'h7ff8_0000_0000_0001 : {32'h7fc0_0001, $urandom};
      default: return {$urandom, $urandom};
    endcase
  endfunction

  function automatic string tag_of(bit v, bit d, bit [2:0] p, bit [63:0] a, bit [63:0] b);
    if (!v) return "R2";
    if (p >= 3'd6) return "R5";
    if (is_nan(d, a[63:32], a[31:0]) || is_nan(d, b[63:32], b[31:0])) return "R9";
    if (order_key(d, a[63:32], a[31:0]) == 64'h8000_0000_0000_0000 &&
        order_key(d, b[63:32], b[31:0]) == 64'h8000_0000_0000_0000) return "R8";
    if (d) return "R7";
    return (p < 3'd3) ? "R3" : "R4";
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cmp_valid = 1'b0; dbl_sel = 1'b0; pred = 3'd0;
    a_even = '0; a_odd = '0; b_even = '0; b_odd = '0;
    repeat (3) @(negedge clk);
    model = 1'b0;
    check("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");

    // directed corner cases
    apply(1, 0, 3'd0, 32'hbf80_0000, 0, 32'h3f80_0000, 0, "R3");      // -1 < 1
    apply(1, 0, 3'd2, 32'h3f80_0000, 32'h0, 32'h3f80_0000, 32'hffff_ffff, "R6");
    apply(1, 0, 3'd5, 32'h3f80_0000, 32'h1, 32'h3f80_0000, 32'h2, "R6");
    apply(1, 1, 3'd0, 32'h3ff0_0000, 32'h0, 32'h3ff0_0000, 32'h1, "R7");
    apply(1, 1, 3'd1, 32'h3ff0_0001, 32'h0, 32'h3ff0_0000, 32'hffff_ffff, "R7");
    apply(1, 0, 3'd2, 32'h8000_0000, 0, 32'h0000_0000, 0, "R8");
    apply(1, 1, 3'd4, 32'h8000_0000, 0, 32'h0, 0, "R8");
    apply(1, 0, 3'd5, 32'h7fc0_0000, 0, 32'h7fc0_0000, 0, "R9");
    apply(1, 1, 3'd3, 32'h7ff0_0000, 1, 32'h0, 0, "R9");
    apply(1, 0, 3'd0, 32'hff80_0000, 0, 32'hbf80_0000, 0, "R10");     // -inf < -1
    apply(1, 0, 3'd1, 32'hc000_0000, 0, 32'hbf80_0000, 0, "R10");     // -2 > -1 false
    apply(1, 1, 3'd3, 32'h7fef_ffff, 32'hffff_ffff, 32'h7ff0_0000, 0, "R10");
    apply(1, 0, 3'd2, 32'h4000_0000, 0, 32'h4000_0000, 0, "R3");
    apply(1, 0, 3'd6, 32'h0, 0, 32'h3f80_0000, 0, "R5");
    apply(1, 0, 3'd7, 32'h3f80_0000, 0, 32'h0, 0, "R5");
    apply(0, 0, 3'd1, 32'h3f80_0000, 0, 32'h0, 0, "R2");
    apply(1, 0, 3'd4, 32'h3f80_0000, 0, 32'h4000_0000, 0, "R4");

    for (int i = 0; i < 4000; i++) begin
      bit        v = ($urandom % 8) != 0;
      bit        d = $urandom % 2;
      bit [2:0]  p = ($urandom % 10 == 0) ? 3'(6 + $urandom % 2) : 3'($urandom % 6);
      bit [63:0] a = pick(d);
      bit [63:0] b;
      case ($urandom % 4)
        0: b = a;
        1: b = a ^ 64'h1;
        default: b = pick(d);
      endcase
      apply(v, d, p, a[63:32], a[31:0], b[63:32], b[31:0], tag_of(v, d, p, a, b));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule